// File: doc/BRIEF.md
# Field-Scheduled Auxiliary ADC Sequencer

This block drives one 6-bit successive-approximation converter. The converter is shared by three slow analog inputs through a multiplexer. The block works in video fields. A one-cycle vertical-flyback pulse starts a short burst of work, and the burst contains two slots. The first slot always converts input 1. The second slot converts input 2 or input 3 in turn, except that once every 32 fields it stores a noise-estimate word instead of converting.

Four result registers hold the outputs: one for each analog input and one for the noise value. Each register has its own data-valid flag. The register bus raises a per-register read strobe when it reads a register. If that strobe lands in the same cycle as an update of the same register, the new value is still stored, but its flag is cleared. The comparator, the DAC and the noise estimator are outside this block. It only presents a trial code and a multiplexer select, and it samples a single comparator bit.

Top module: `aux_adc_sequencer`

## Requirements
- R1: Each conversion resolves CODE_W = 6 bits from the most significant bit to the least. In each step the trial bit is set on `dac_code`, the bit is kept when `cmp_hi` is 1, and it is cleared otherwise. The stored result is therefore the largest code for which the comparator reported 1.
- R2: A flyback sampled while idle starts slot one on the next cycle. From that cycle `busy` is 1, `mux_sel` is 1 and `dac_code` is 6'b100000. A conversion takes 6 cycles, and the result register is written at the sixth rising edge after the conversion starts.
- R3: Input 1 (`mux_sel` = 1) is converted in the first slot of every field, and its result goes to `res_in1`.
- R4: The field index is the value of the field counter when the flyback is accepted. If the index is even and nonzero, the second slot converts input 2 (`mux_sel` = 2) into `res_in2`. If the index is odd, the second slot converts input 3 (`mux_sel` = 3) into `res_in3`. The register that is not scheduled keeps its value.
- R5: If the field index is 0, the second slot makes no conversion. Instead, `noise_word` is loaded into `noise_res` one cycle after the first slot is stored, and `res_in2` is left unchanged.
- R6: The field counter is FIELD_W = 5 bits wide. Reset clears it to 0, each accepted flyback advances it by one, and it wraps from 31 to 0. The first field after reset and every 32nd field after that therefore update the noise register.
- R7: If `rd_conflict[i]` is 1 on the edge that writes register i, the new value is stored and `data_valid[i]` becomes 0. Bit mapping: 0 = `res_in1`, 1 = `res_in2`, 2 = `res_in3`, 3 = `noise_res`.
- R8: An update with no conflict sets `data_valid[i]` to 1. A conflict strobe on a cycle that does not update register i changes neither its data nor its flag.
- R9: A flyback that arrives while `busy` is 1 is ignored. It starts no extra conversion and does not advance the field counter.
- R10: Reset clears all result registers, all valid flags, `busy`, `mux_sel` and `dac_code` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| flyback | input | 1 | One-cycle vertical flyback pulse |
| cmp_hi | input | 1 | Comparator: selected input is at or above `dac_code` |
| noise_word | input | 6 | Current noise estimate to be stored |
| rd_conflict | input | 4 | Per-register bus read strobe |
| dac_code | output | 6 | Trial code for the external DAC |
| mux_sel | output | 2 | Selected input: 0 none, 1..3 input number |
| busy | output | 1 | A field burst is in progress |
| res_in1 | output | 6 | Result of input 1 |
| res_in2 | output | 6 | Result of input 2 |
| res_in3 | output | 6 | Result of input 3 |
| noise_res | output | 6 | Stored noise value |
| data_valid | output | 4 | Valid flag for each result register |

## Verification
Two events can fall in the same cycle: a register update and a bus read of that register. The bench lines up a read strobe exactly with the writing edge of a chosen register. That edge is the 6th edge after the burst starts for slot one, the 7th for a noise update, and the 12th for a slot-two conversion. The bench then expects the new data with the flag cleared.

Read strobes in other cycles are also raised. These off-cycle strobes must leave the flags untouched. The same is required of a second flyback that arrives during a burst.

// File: rtl/aux_adc_pkg.sv
// Shared constants and types for the auxiliary converter sequencer.
// Assumes one converter and a fixed set of four result registers.
package aux_adc_pkg;
    localparam int unsigned CODE_W  = 6;   // converter resolution
    localparam int unsigned FIELD_W = 5;   // field counter width (32-field rotation)
    localparam int unsigned NUM_REG = 4;   // three inputs plus noise register

    // Register index used for update and conflict vectors
    localparam int unsigned IDX_IN1   = 0;
    localparam int unsigned IDX_IN2   = 1;
    localparam int unsigned IDX_IN3   = 2;
    localparam int unsigned IDX_NOISE = 3;

    typedef enum logic [1:0] {
        SEQ_IDLE,
        SEQ_SLOT_A,
        SEQ_SLOT_B,
        SEQ_NOISE
    } seq_state_t;
endpackage

// File: rtl/aux_field_sched.sv
// Field counter and slot planner.
// Counts accepted flyback pulses and reports, for the current count,
// whether slot two is the noise update and whether the field is odd.
// Assumes 'advance' is asserted only for accepted flybacks.
module aux_field_sched #(
    parameter int unsigned FW = aux_adc_pkg::FIELD_W
) (
    input  logic clk,
    input  logic rst_n,
    input  logic advance,
    output logic noise_slot,
    output logic odd_field
);
    logic [FW-1:0] fcnt;

    // Advance the field count once per accepted flyback, wrapping naturally
    always_ff @(posedge clk) begin
        if (!rst_n)       fcnt <= '0;
        else if (advance) fcnt <= fcnt + 1'b1;
    end

    // Decode the schedule for the field about to run
    always_comb begin
        noise_slot = (fcnt == '0);
        odd_field  = fcnt[0];
    end
endmodule

// File: rtl/aux_sar_engine.sv
// Successive-approximation step engine.
// 'start' loads a fresh conversion; each following cycle presents a trial
// code, and the next edge keeps or clears the trial bit from 'cmp_hi'.
// 'last' marks the final step; 'result_next' is the finished code then.
// Assumes the comparator settles within one cycle of a trial code.
module aux_sar_engine #(
    parameter int unsigned W = aux_adc_pkg::CODE_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic         cmp_hi,
    output logic [W-1:0] trial,
    output logic         last,
    output logic [W-1:0] result_next
);
    localparam int unsigned PW = (W > 1) ? $clog2(W) : 1;

    logic [W-1:0]  acc;
    logic [PW-1:0] bitpos;
    logic          active;
    logic [W-1:0]  probe;

    // Form the trial code and the value kept at the coming edge
    always_comb begin
        probe       = {{(W-1){1'b0}}, 1'b1} << bitpos;
        trial       = active ? (acc | probe) : '0;
        last        = active && (bitpos == '0);
        result_next = cmp_hi ? (acc | probe) : acc;
    end

    // Step the approximation one bit per cycle, MSB first
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc    <= '0;
            bitpos <= '0;
            active <= 1'b0;
        end else if (start) begin
            acc    <= '0;
            bitpos <= PW'(W-1);
            active <= 1'b1;
        end else if (active) begin
            acc <= result_next;
            if (bitpos == '0) active <= 1'b0;
            else              bitpos <= bitpos - 1'b1;
        end
    end
endmodule

// File: rtl/aux_result_bank.sv
// Result registers with per-register valid flags.
// An update stores wdata; the flag follows the absence of a bus read
// conflict on that same edge. Other cycles leave both untouched.
// Assumes at most one update bit is set per cycle.
module aux_result_bank #(
    parameter int unsigned W = aux_adc_pkg::CODE_W,
    parameter int unsigned N = aux_adc_pkg::NUM_REG
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [N-1:0]        upd,
    input  logic [N-1:0]        conflict,
    input  logic [W-1:0]        wdata,
    output logic [N-1:0][W-1:0] data,
    output logic [N-1:0]        valid
);
    for (genvar g = 0; g < N; g++) begin : g_reg
        // Store one register and qualify it against a same-edge read
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                data[g]  <= '0;
                valid[g] <= 1'b0;
            end else if (upd[g]) begin
                data[g]  <= wdata;
                valid[g] <= !conflict[g];
            end
        end
    end
endmodule

// File: rtl/aux_adc_sequencer.sv
// Field-scheduled auxiliary converter sequencer (top).
// On an accepted flyback it converts input 1, then either input 2/3 or
// stores the noise word, according to the field planner. Flybacks during
// a burst are ignored. Assumes the burst finishes well within a field.
module aux_adc_sequencer
    import aux_adc_pkg::*;
#(
    parameter int unsigned CODE_BITS  = CODE_W,
    parameter int unsigned FIELD_BITS = FIELD_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 flyback,
    input  logic                 cmp_hi,
    input  logic [CODE_BITS-1:0] noise_word,
    input  logic [NUM_REG-1:0]   rd_conflict,
    output logic [CODE_BITS-1:0] dac_code,
    output logic [1:0]           mux_sel,
    output logic                 busy,
    output logic [CODE_BITS-1:0] res_in1,
    output logic [CODE_BITS-1:0] res_in2,
    output logic [CODE_BITS-1:0] res_in3,
    output logic [CODE_BITS-1:0] noise_res,
    output logic [NUM_REG-1:0]   data_valid
);
    seq_state_t                         state;
    logic                               noise_pend;
    logic [1:0]                         ch_b;
    logic                               noise_slot;
    logic                               odd_field;
    logic                               accept;
    logic                               sar_start;
    logic                               sar_last;
    logic [CODE_BITS-1:0]               sar_res;
    logic [NUM_REG-1:0]                 upd;
    logic [CODE_BITS-1:0]               wdata;
    logic [NUM_REG-1:0][CODE_BITS-1:0]  bank;

    aux_field_sched #(.FW(FIELD_BITS)) u_sched (
        .clk        (clk),
        .rst_n      (rst_n),
        .advance    (accept),
        .noise_slot (noise_slot),
        .odd_field  (odd_field)
    );

    aux_sar_engine #(.W(CODE_BITS)) u_sar (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (sar_start),
        .cmp_hi      (cmp_hi),
        .trial       (dac_code),
        .last        (sar_last),
        .result_next (sar_res)
    );

    aux_result_bank #(.W(CODE_BITS), .N(NUM_REG)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .upd      (upd),
        .conflict (rd_conflict),
        .wdata    (wdata),
        .data     (bank),
        .valid    (data_valid)
    );

    // Decode burst start, conversion starts, register updates and write data
    always_comb begin
        accept    = (state == SEQ_IDLE) && flyback;
        sar_start = accept || ((state == SEQ_SLOT_A) && sar_last && !noise_pend);
        upd            = '0;
        upd[IDX_IN1]   = (state == SEQ_SLOT_A) && sar_last;
        upd[IDX_IN2]   = (state == SEQ_SLOT_B) && sar_last && (mux_sel == 2'd2);
        upd[IDX_IN3]   = (state == SEQ_SLOT_B) && sar_last && (mux_sel == 2'd3);
        upd[IDX_NOISE] = (state == SEQ_NOISE);
        wdata     = (state == SEQ_NOISE) ? noise_word : sar_res;
        busy      = (state != SEQ_IDLE);
    end

    // Walk the two slots of a field burst and steer the input multiplexer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= SEQ_IDLE;
            mux_sel    <= 2'd0;
            noise_pend <= 1'b0;
            ch_b       <= 2'd2;
        end else begin
            case (state)
                SEQ_IDLE: if (flyback) begin
                    state      <= SEQ_SLOT_A;
                    mux_sel    <= 2'd1;
                    noise_pend <= noise_slot;
                    ch_b       <= odd_field ? 2'd3 : 2'd2;
                end
                SEQ_SLOT_A: if (sar_last) begin
                    if (noise_pend) begin
                        state   <= SEQ_NOISE;
                        mux_sel <= 2'd0;
                    end else begin
                        state   <= SEQ_SLOT_B;
                        mux_sel <= ch_b;
                    end
                end
                SEQ_SLOT_B: if (sar_last) begin
                    state   <= SEQ_IDLE;
                    mux_sel <= 2'd0;
                end
                default: state <= SEQ_IDLE;
            endcase
        end
    end

    // Present the register bank on named ports
    always_comb begin
        res_in1   = bank[IDX_IN1];
        res_in2   = bank[IDX_IN2];
        res_in3   = bank[IDX_IN3];
        noise_res = bank[IDX_NOISE];
    end
endmodule

// File: rtl/aux_adc_seq_chk.sv
// Property checker for the sequencer, attached by bind.
// Watches the port behaviour and the update strobes between the
// sequencing logic and the result bank.
module aux_adc_seq_chk
    import aux_adc_pkg::*;
#(
    parameter int unsigned CODE_BITS = CODE_W
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 flyback,
    input logic                 busy,
    input logic [1:0]           mux_sel,
    input logic [CODE_BITS-1:0] dac_code,
    input logic [NUM_REG-1:0]   rd_conflict,
    input logic [NUM_REG-1:0]   upd,
    input logic [NUM_REG-1:0]   data_valid
);
    // R2
    burst_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flyback && !busy |=> busy && mux_sel == 2'd1);

    // R1
    msb_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> dac_code == {1'b1, {(CODE_BITS-1){1'b0}}});

    // R9
    ignore_flyback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy && flyback |=> $stable(mux_sel) || $past(upd) != '0);

    // R7
    single_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(upd));

    for (genvar i = 0; i < NUM_REG; i++) begin : g_flag
        // R7
        conflict_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
            upd[i] && rd_conflict[i] |=> !data_valid[i]);
        // R8
        clean_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
            upd[i] && !rd_conflict[i] |=> data_valid[i]);
        // R8
        flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !upd[i] |=> $stable(data_valid[i]));
    end
endmodule

bind aux_adc_sequencer aux_adc_seq_chk #(.CODE_BITS(CODE_BITS)) u_seq_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .flyback     (flyback),
    .busy        (busy),
    .mux_sel     (mux_sel),
    .dac_code    (dac_code),
    .rd_conflict (rd_conflict),
    .upd         (upd),
    .data_valid  (data_valid)
);

// File: tb/test_aux_adc_sequencer.sv
// Bench: models the analog inputs and comparator, runs 64 fields with
// random levels, strobes and directed corners, and checks all results.
module test_aux_adc_sequencer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       flyback = 1'b0;
    logic       cmp_hi;
    logic [5:0] noise_word = '0;
    logic [3:0] rd_conflict = '0;
    logic [5:0] dac_code;
    logic [1:0] mux_sel;
    logic       busy;
    logic [5:0] res_in1, res_in2, res_in3, noise_res;
    logic [3:0] data_valid;

    logic [5:0] lvl1 = '0, lvl2 = '0, lvl3 = '0;
    int         nvec = 0;
    int         nfail = 0;
    int         fc = 0;
    logic [5:0] e_data [4];
    logic       e_val  [4];

    always #4 clk = ~clk;   // 125 MHz

    aux_adc_sequencer i_aux_adc_sequencer (
        .clk(clk), .rst_n(rst_n), .flyback(flyback), .cmp_hi(cmp_hi),
        .noise_word(noise_word), .rd_conflict(rd_conflict),
        .dac_code(dac_code), .mux_sel(mux_sel), .busy(busy),
        .res_in1(res_in1), .res_in2(res_in2), .res_in3(res_in3),
        .noise_res(noise_res), .data_valid(data_valid)
    );

    // Comparator model: selected level at or above trial code
    always_comb begin
        case (mux_sel)
            2'd1:    cmp_hi = (lvl1 >= dac_code);
            2'd2:    cmp_hi = (lvl2 >= dac_code);
            2'd3:    cmp_hi = (lvl3 >= dac_code);
            default: cmp_hi = 1'b0;
        endcase
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        nvec++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic check_bank(input string req);
        chk(req, "res_in1",   res_in1,   e_data[0]);
        chk(req, "res_in2",   res_in2,   e_data[1]);
        chk(req, "res_in3",   res_in3,   e_data[2]);
        chk(req, "noise_res", noise_res, e_data[3]);
        for (int i = 0; i < 4; i++) chk(req, $sformatf("valid[%0d]", i), data_valid[i], e_val[i]);
    endtask

    // One field burst; cA/cB collide reads with slot one/two writes
    task automatic run_field(input logic [5:0] a1, input logic [5:0] a2, input logic [5:0] a3,
                             input logic [5:0] nw, input bit cA, input bit cB,
                             input bit stray, input bit dup);
        bit noise = ((fc % 32) == 0);
        int chb   = (fc % 2 == 1) ? 2 : 1;   // register index of slot two
        lvl1 = a1; lvl2 = a2; lvl3 = a3; noise_word = nw;
        @(negedge clk);
        flyback = 1'b1;
        for (int j = 1; j <= 16; j++) begin
            @(negedge clk);
            flyback = dup && (j == 3);
            rd_conflict = '0;
            if (stray && j == 3) rd_conflict = 4'hF;
            if (cA && j == 6) rd_conflict[0] = 1'b1;
            if (noise && cB && j == 7) rd_conflict[3] = 1'b1;
            if (!noise && cB && j == 12) rd_conflict[chb] = 1'b1;
            if (j == 1) begin
                chk("R2", "busy at start", busy, 1);
                chk("R3", "mux_sel slot one", mux_sel, 1);
                chk("R1", "first trial code", dac_code, 32);
            end
            if (j == 8 && !noise) chk("R4", "mux_sel slot two", mux_sel, chb + 1);
        end
        @(negedge clk);
        rd_conflict = '0;
        e_data[0] = a1; e_val[0] = !cA;
        if (noise) begin
            e_data[3] = nw; e_val[3] = !cB;
        end else begin
            e_data[chb] = (chb == 1) ? a2 : a3;
            e_val[chb]  = !cB;
        end
        chk("R9", "busy after burst", busy, 0);
        if (noise)       check_bank("R5_R6");
        else if (cA|cB)  check_bank("R7");
        else if (stray)  check_bank("R8");
        else             check_bank("R4");
        fc++;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        #(8 * 150000);
        nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 4; i++) begin e_data[i] = '0; e_val[i] = 1'b0; end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        chk("R10", "busy", busy, 0);
        chk("R10", "mux_sel", mux_sel, 0);
        chk("R10", "dac_code", dac_code, 0);
        check_bank("R10");
        // Directed corners
        run_field(6'd17, 6'd5, 6'd9, 6'd42, 1'b0, 1'b1, 1'b0, 1'b0); // field 0: noise collides
        run_field(6'd0, 6'd7, 6'd63, 6'd1, 1'b0, 1'b0, 1'b0, 1'b0);  // field 1: extremes
        run_field(6'd63, 6'd0, 6'd8, 6'd2, 1'b0, 1'b0, 1'b1, 1'b0);  // field 2: stray reads
        run_field(6'd21, 6'd3, 6'd44, 6'd3, 1'b1, 1'b0, 1'b0, 1'b1); // field 3: slot-one collide, dup flyback
        run_field(6'd33, 6'd34, 6'd35, 6'd4, 1'b0, 1'b0, 1'b0, 1'b0); // R8 recovery
        while (fc < 64) begin
            run_field(6'($urandom_range(0, 63)), 6'($urandom_range(0, 63)),
                      6'($urandom_range(0, 63)), 6'($urandom_range(0, 63)),
                      ($urandom_range(0, 2) == 0), ($urandom_range(0, 2) == 0),
                      ($urandom_range(0, 3) == 0), (fc == 40) || ($urandom_range(0, 7) == 0));
        end
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end
endmodule